// File: doc/BRIEF.md
# Two-Stage Multiple-Bus Request Allocator

This block arbitrates a shared-memory system in which several processors reach several memory modules over a small pool of identical buses. Every clock it samples all processor requests together. Each request names one target memory module. It then grants processor-to-memory connections. Allocation happens in two ordered stages. First, each memory module that is idle picks at most one requester. Only after that are the free buses handed to the modules that were picked. Because of this order, a bus is never spent on a request whose module is already claimed or busy.

The block uses circuit switching. A granted connection keeps its bus, its memory module and its processor for a fixed operation length of `OP_LEN` clocks. None of the three is offered again until the final clock of that operation. A request that is refused must be held unchanged by the processor until it is granted. Fairness comes from two rotating priorities. Inside a module, a pointer rotates over the requesters. When more modules are picked than there are free buses, a global pointer that advances every clock sets the order in which the picked modules claim buses. A grant is a one-clock pulse per processor and carries the index of the assigned bus.

Top module: `mba_alloc`

## Requirements
- R1: While reset is asserted, and in the first clock after it, `gnt_o` and `bus_busy_o` are all zero.
- R2: A grant to processor p appears on `gnt_o[p]` in the clock after an edge at which `req_i[p]` was high. It lasts one clock. A processor that is still inside its own operation is not granted.
- R3: Within one grant cycle, no two granted processors target the same memory module. A module that is still inside an operation receives no grant. The target of processor p is field `req_mem_i[p*MW +: MW]`.
- R4: The number of grants issued at an edge equals the smaller of two counts: the free buses, and the distinct idle modules requested by processors that are not themselves busy.
- R5: The grants of one cycle use distinct bus indices, and each index names a bus that was free. The bus of processor p is field `gnt_bus_o[p*BW +: BW]`.
- R6: `bus_busy_o[b]` goes high in the grant cycle and stays high for exactly `OP_LEN` clocks. The bus can be granted again at the earliest `OP_LEN` clocks after its previous grant, which keeps the bus busy without a gap.
- R7: When several processors contend for one module, the next winner is the first requester after the previous winner in ascending circular processor order. After reset, processor 0 has priority.
- R8: The K grants of an edge take the K lowest-indexed free buses.
- R9: A request that is held until granted is granted within a bounded number of clocks, so no requester starves.
- R10: When no requested module is idle, no bus is assigned, even if buses are free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; one allocation per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | N_PROC | Request valid, one bit per processor |
| req_mem_i | input | N_PROC*MW | Target module per processor, field p at bits p*MW upward |
| gnt_o | output | N_PROC | One-clock grant pulse per processor |
| gnt_bus_o | output | N_PROC*BW | Bus index per processor, valid with its grant |
| bus_busy_o | output | N_BUS | Bus holds a connection |

## Verification
The bench builds the block with four processors, four modules, two buses and a three-clock operation. With this setup, module contention and bus shortage both occur every few clocks. The run includes:
- a phase where every processor targets a single module, which walks the round-robin winner order through all four requesters several times;
- a phase with one module per processor, which asks for twice as many connections as there are buses;
- sweeps at three request densities, with a bench-side occupancy model that predicts the grant count, the bus choice and the busy flags at every edge.

// File: rtl/mba_pkg.sv
`timescale 1ns/1ps
package mba_pkg;
   // Index width for a set of n items; at least one bit.
   function automatic int idx_w(input int n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/mba_mem_arb.sv
`timescale 1ns/1ps
// Stage one: pick at most one requester for one memory module, rotating priority.
module mba_mem_arb #(
   parameter int N_PROC = 4,
   localparam int PW = mba_pkg::idx_w(N_PROC)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [N_PROC-1:0] cand_i,
   input  logic              take_i,
   output logic              win_o,
   output logic [PW-1:0]     win_idx_o
);
   logic [PW-1:0] ptr_q;

   always_comb begin
      logic [PW-1:0] j;
      win_o     = 1'b0;
      win_idx_o = '0;
      for (int i = 0; i < N_PROC; i++) begin
         j = PW'((int'(ptr_q) + i) % N_PROC);
         if (!win_o && cand_i[j]) begin
            win_o     = 1'b1;
            win_idx_o = j;
         end
      end
   end

   // Pointer moves past the winner only once the winner is actually connected.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         ptr_q <= '0;
      else if (take_i)
         ptr_q <= (int'(win_idx_o) == N_PROC - 1) ? '0 : win_idx_o + 1'b1;
   end
endmodule

// File: rtl/mba_bus_assign.sv
`timescale 1ns/1ps
// Stage two: hand free buses to selected modules in rotating module order.
module mba_bus_assign #(
   parameter int N_MEM = 4,
   parameter int N_BUS = 2,
   localparam int MW = mba_pkg::idx_w(N_MEM),
   localparam int BW = mba_pkg::idx_w(N_BUS)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N_MEM-1:0] sel_i,
   input  logic [N_BUS-1:0] bus_free_i,
   output logic [N_MEM-1:0] take_o,
   output logic [BW-1:0]    bus_idx_o [N_MEM]
);
   logic [MW-1:0] gptr_q;

   always_comb begin
      logic [N_BUS-1:0] used;
      logic [MW-1:0]    m;
      used   = '0;
      take_o = '0;
      for (int k = 0; k < N_MEM; k++) bus_idx_o[k] = '0;
      for (int i = 0; i < N_MEM; i++) begin
         m = MW'((int'(gptr_q) + i) % N_MEM);
         if (sel_i[m]) begin
            for (int b = 0; b < N_BUS; b++) begin
               if (!take_o[m] && bus_free_i[b] && !used[b]) begin
                  take_o[m]    = 1'b1;
                  used[b]      = 1'b1;
                  bus_idx_o[m] = BW'(b);
               end
            end
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         gptr_q <= '0;
      else
         gptr_q <= (int'(gptr_q) == N_MEM - 1) ? '0 : gptr_q + 1'b1;
   end
endmodule

// File: rtl/mba_bus_track.sv
`timescale 1ns/1ps
// Occupancy of one bus: remaining clocks plus the processor and module it links.
module mba_bus_track #(
   parameter int OP_LEN = 3,
   parameter int PW = 2,
   parameter int MW = 2,
   localparam int CW = $clog2(OP_LEN + 1)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          load_i,
   input  logic [PW-1:0] proc_i,
   input  logic [MW-1:0] mem_i,
   output logic          free_o,
   output logic          busy_o,
   output logic [PW-1:0] proc_o,
   output logic [MW-1:0] mem_o
);
   logic [CW-1:0] cnt_q;

   // Free during the last clock of an operation so connections run back to back.
   assign free_o = (cnt_q <= CW'(1));
   assign busy_o = (cnt_q != '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         proc_o <= '0;
         mem_o  <= '0;
      end else if (load_i) begin
         cnt_q  <= CW'(OP_LEN);
         proc_o <= proc_i;
         mem_o  <= mem_i;
      end else if (cnt_q != '0) begin
         cnt_q  <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/mba_alloc.sv
`timescale 1ns/1ps
module mba_alloc #(
   parameter int N_PROC = 4,
   parameter int N_MEM  = 4,
   parameter int N_BUS  = 2,
   parameter int OP_LEN = 3,
   localparam int PW = mba_pkg::idx_w(N_PROC),
   localparam int MW = mba_pkg::idx_w(N_MEM),
   localparam int BW = mba_pkg::idx_w(N_BUS)
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [N_PROC-1:0]    req_i,
   input  logic [N_PROC*MW-1:0] req_mem_i,
   output logic [N_PROC-1:0]    gnt_o,
   output logic [N_PROC*BW-1:0] gnt_bus_o,
   output logic [N_BUS-1:0]     bus_busy_o
);
   if (N_PROC < 2) begin : g_chk_proc
      $error("mba_alloc: N_PROC must be at least 2");
   end
   if (N_MEM < 2) begin : g_chk_mem
      $error("mba_alloc: N_MEM must be at least 2");
   end
   if (N_BUS < 2) begin : g_chk_bus
      $error("mba_alloc: N_BUS must be at least 2");
   end
   if (OP_LEN < 1) begin : g_chk_op
      $error("mba_alloc: OP_LEN must be at least 1");
   end

   logic [MW-1:0]     mem_of  [N_PROC];
   logic [N_BUS-1:0]  b_free, b_busy, load;
   logic [PW-1:0]     b_proc  [N_BUS];
   logic [MW-1:0]     b_mem   [N_BUS];
   logic [PW-1:0]     ld_proc [N_BUS];
   logic [MW-1:0]     ld_mem  [N_BUS];
   logic [N_PROC-1:0] proc_hold;
   logic [N_MEM-1:0]  mem_hold, sel, take;
   logic [N_PROC-1:0] cand    [N_MEM];
   logic [PW-1:0]     win_idx [N_MEM];
   logic [BW-1:0]     mbus    [N_MEM];
   logic [N_PROC-1:0]    nxt_gnt;
   logic [N_PROC*BW-1:0] nxt_bus;

   for (genvar p = 0; p < N_PROC; p++) begin : g_unpack
      assign mem_of[p] = req_mem_i[p*MW +: MW];
   end

   // Processors and modules tied to a bus that is not yet free are masked.
   always_comb begin
      proc_hold = '0;
      mem_hold  = '0;
      for (int b = 0; b < N_BUS; b++) begin
         if (!b_free[b]) begin
            proc_hold[b_proc[b]] = 1'b1;
            mem_hold[b_mem[b]]   = 1'b1;
         end
      end
   end

   always_comb begin
      for (int m = 0; m < N_MEM; m++)
         for (int p = 0; p < N_PROC; p++)
            cand[m][p] = req_i[p] && !proc_hold[p] && !mem_hold[m] &&
                         (mem_of[p] == MW'(m));
   end

   for (genvar m = 0; m < N_MEM; m++) begin : g_arb
      mba_mem_arb #(.N_PROC(N_PROC)) u_arb (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .cand_i    (cand[m]),
         .take_i    (take[m]),
         .win_o     (sel[m]),
         .win_idx_o (win_idx[m])
      );
   end

   mba_bus_assign #(.N_MEM(N_MEM), .N_BUS(N_BUS)) u_assign (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sel_i      (sel),
      .bus_free_i (b_free),
      .take_o     (take),
      .bus_idx_o  (mbus)
   );

   always_comb begin
      load    = '0;
      nxt_gnt = '0;
      nxt_bus = '0;
      for (int b = 0; b < N_BUS; b++) begin
         ld_proc[b] = '0;
         ld_mem[b]  = '0;
      end
      for (int m = 0; m < N_MEM; m++) begin
         if (take[m]) begin
            load[mbus[m]]    = 1'b1;
            ld_proc[mbus[m]] = win_idx[m];
            ld_mem[mbus[m]]  = MW'(m);
            nxt_gnt[win_idx[m]] = 1'b1;
            nxt_bus[int'(win_idx[m])*BW +: BW] = mbus[m];
         end
      end
   end

   for (genvar b = 0; b < N_BUS; b++) begin : g_bus
      mba_bus_track #(.OP_LEN(OP_LEN), .PW(PW), .MW(MW)) u_track (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .load_i (load[b]),
         .proc_i (ld_proc[b]),
         .mem_i  (ld_mem[b]),
         .free_o (b_free[b]),
         .busy_o (b_busy[b]),
         .proc_o (b_proc[b]),
         .mem_o  (b_mem[b])
      );
   end

   assign bus_busy_o = b_busy;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gnt_o     <= '0;
         gnt_bus_o <= '0;
      end else begin
         gnt_o     <= nxt_gnt;
         gnt_bus_o <= nxt_bus;
      end
   end
endmodule

// File: rtl/mba_alloc_chk.sv
`timescale 1ns/1ps
module mba_alloc_chk #(
   parameter int N_PROC = 4,
   parameter int N_MEM  = 4,
   parameter int N_BUS  = 2,
   parameter int OP_LEN = 3,
   localparam int MW = mba_pkg::idx_w(N_MEM),
   localparam int BW = mba_pkg::idx_w(N_BUS),
   localparam int CW = $clog2(OP_LEN + 1)
) (
   input logic                 clk_i,
   input logic                 rst_ni,
   input logic [N_PROC-1:0]    req_i,
   input logic [N_PROC*MW-1:0] req_mem_i,
   input logic [N_PROC-1:0]    gnt_o,
   input logic [N_PROC*BW-1:0] gnt_bus_o,
   input logic [N_BUS-1:0]     bus_busy_o
);
   logic [N_PROC-1:0]    bus_hit [N_BUS];
   logic [N_PROC-1:0]    mem_hit [N_MEM];
   logic [N_PROC*MW-1:0] mem_q;
   logic [CW-1:0]        age_q   [N_BUS];

   always_comb begin
      for (int b = 0; b < N_BUS; b++)
         for (int p = 0; p < N_PROC; p++)
            bus_hit[b][p] = gnt_o[p] && (gnt_bus_o[p*BW +: BW] == BW'(b));
      for (int m = 0; m < N_MEM; m++)
         for (int p = 0; p < N_PROC; p++)
            mem_hit[m][p] = gnt_o[p] && (mem_q[p*MW +: MW] == MW'(m));
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mem_q <= '0;
         for (int b = 0; b < N_BUS; b++) age_q[b] <= '0;
      end else begin
         mem_q <= req_mem_i;
         for (int b = 0; b < N_BUS; b++) begin
            if (|bus_hit[b])
               age_q[b] <= CW'(1);
            else if (age_q[b] != '0 && age_q[b] < CW'(OP_LEN))
               age_q[b] <= age_q[b] + 1'b1;
         end
      end
   end

   for (genvar p = 0; p < N_PROC; p++) begin : g_p
      p_gnt_needs_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
         gnt_o[p] |-> $past(req_i[p]));
      if (OP_LEN > 1) begin : g_pulse
         p_gnt_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            gnt_o[p] |=> !gnt_o[p]);
      end
   end

   for (genvar m = 0; m < N_MEM; m++) begin : g_m
      p_mem_once_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $countones(mem_hit[m]) <= 1);
   end

   for (genvar b = 0; b < N_BUS; b++) begin : g_b
      p_bus_once_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $countones(bus_hit[b]) <= 1);
      p_busy_on_gnt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (|bus_hit[b]) |-> bus_busy_o[b]);
      p_no_early_regrant_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (|bus_hit[b]) |-> (age_q[b] == '0 || age_q[b] >= CW'(OP_LEN)));
      p_busy_length_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $fell(bus_busy_o[b]) |-> (age_q[b] == CW'(OP_LEN)));
      p_busy_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(bus_busy_o[b]) |-> (|bus_hit[b]));
   end
endmodule

bind mba_alloc mba_alloc_chk #(
   .N_PROC(N_PROC), .N_MEM(N_MEM), .N_BUS(N_BUS), .OP_LEN(OP_LEN)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .req_i      (req_i),
   .req_mem_i  (req_mem_i),
   .gnt_o      (gnt_o),
   .gnt_bus_o  (gnt_bus_o),
   .bus_busy_o (bus_busy_o)
);

// File: tb/mba_alloc_tb_top.sv
`timescale 1ns/1ps
module mba_alloc_tb_top;
   localparam int N = 4, M = 4, B = 2, OP = 3, MW = 2, BW = 1;
   localparam int WAIT_MAX = 100;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [N-1:0]    req_i;
   logic [N*MW-1:0] req_mem_i;
   logic [N-1:0]    gnt_o;
   logic [N*BW-1:0] gnt_bus_o;
   logic [B-1:0]    bus_busy_o;

   mba_alloc #(.N_PROC(N), .N_MEM(M), .N_BUS(B), .OP_LEN(OP)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req_i), .req_mem_i(req_mem_i),
      .gnt_o(gnt_o), .gnt_bus_o(gnt_bus_o), .bus_busy_o(bus_busy_o));

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;
   int rem [B];
   int bproc [B];
   int bmem [B];
   bit req_ap [N];
   int mem_ap [N];
   int waitc [N];
   int max_wait;
   int phase;
   int rr_next;

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic apply();
      for (int p = 0; p < N; p++) begin
         req_i[p] = req_ap[p];
         req_mem_i[p*MW +: MW] = MW'(mem_ap[p]);
      end
   endtask

   // Called at a falling edge: compare the result of the last rising edge.
   task automatic eval_cycle();
      bit bfree [B];
      bit holdp [N];
      bit holdm [M];
      bit elig [N];
      bit dm [M];
      bit busused [B];
      bit memused [M];
      int d, fb, expk, k, any_req, need, expmask, obsmask, bb;
      for (int p = 0; p < N; p++) begin holdp[p] = 0; end
      for (int m = 0; m < M; m++) begin holdm[m] = 0; dm[m] = 0; memused[m] = 0; end
      fb = 0;
      for (int b = 0; b < B; b++) begin
         bfree[b] = (rem[b] <= 1);
         busused[b] = 0;
         if (bfree[b]) fb++;
         else begin holdp[bproc[b]] = 1; holdm[bmem[b]] = 1; end
      end
      d = 0; any_req = 0;
      for (int p = 0; p < N; p++) begin
         elig[p] = req_ap[p] && !holdp[p] && !holdm[mem_ap[p]];
         if (req_ap[p]) any_req = 1;
         if (elig[p] && !dm[mem_ap[p]]) begin dm[mem_ap[p]] = 1; d++; end
      end
      expk = (d < fb) ? d : fb;
      k = $countones(gnt_o);
      chk(k == expk, "R4 grant count", k, expk);
      if (any_req && d == 0) chk(k == 0, "R10 no bus for busy module", k, 0);
      obsmask = 0;
      for (int p = 0; p < N; p++) begin
         if (gnt_o[p]) begin
            bb = int'(gnt_bus_o[p*BW +: BW]);
            chk(elig[p], "R2 grant to eligible requester", p, 1);
            chk(bfree[bb] && !busused[bb], "R5 bus free and unique", bb, 1);
            chk(!memused[mem_ap[p]], "R3 module granted once", mem_ap[p], 1);
            busused[bb] = 1;
            memused[mem_ap[p]] = 1;
            obsmask |= (1 << bb);
            if (phase == 0) begin
               chk(p == rr_next, "R7 round-robin winner", p, rr_next);
               rr_next = (p + 1) % N;
            end
         end
      end
      expmask = 0; need = k;
      for (int b = 0; b < B; b++)
         if (bfree[b] && need > 0) begin expmask |= (1 << b); need--; end
      chk(obsmask == expmask, "R8 lowest free buses", obsmask, expmask);
      for (int b = 0; b < B; b++) if (rem[b] > 0) rem[b]--;
      for (int p = 0; p < N; p++)
         if (gnt_o[p]) begin
            bb = int'(gnt_bus_o[p*BW +: BW]);
            rem[bb] = OP; bproc[bb] = p; bmem[bb] = mem_ap[p];
         end
      for (int b = 0; b < B; b++)
         chk(bus_busy_o[b] == (rem[b] != 0), "R6 bus busy span", bus_busy_o[b], rem[b] != 0);
      for (int p = 0; p < N; p++) begin
         if (req_ap[p] && !gnt_o[p]) waitc[p]++;
         else waitc[p] = 0;
         if (waitc[p] > max_wait) max_wait = waitc[p];
      end
   endtask

   task automatic drive_next();
      for (int p = 0; p < N; p++) begin
         if (!(req_ap[p] && !gnt_o[p])) begin
            case (phase)
               0: begin req_ap[p] = 1; mem_ap[p] = 0; end
               1: begin req_ap[p] = 1; mem_ap[p] = p; end
               2, 3, 4: begin
                  req_ap[p] = (($urandom % 4) < (phase - 1));
                  mem_ap[p] = $urandom % M;
               end
               default: begin req_ap[p] = 0; mem_ap[p] = 0; end
            endcase
         end
      end
      apply();
   endtask

   initial begin
      for (int b = 0; b < B; b++) begin rem[b] = 0; bproc[b] = 0; bmem[b] = 0; end
      for (int p = 0; p < N; p++) begin req_ap[p] = 0; mem_ap[p] = 0; waitc[p] = 0; end
      rr_next = 0; phase = 0;
      apply();
      repeat (4) @(negedge clk);
      chk(gnt_o == '0, "R1 grants in reset", gnt_o, 0);
      chk(bus_busy_o == '0, "R1 busy in reset", bus_busy_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(gnt_o == '0, "R1 grants after reset", gnt_o, 0);
      chk(bus_busy_o == '0, "R1 busy after reset", bus_busy_o, 0);
      drive_next();
      for (int ph = 0; ph < 6; ph++) begin
         phase = ph;
         max_wait = 0;
         for (int c = 0; c < ((ph >= 2 && ph <= 4) ? 400 : 200); c++) begin
            @(negedge clk);
            eval_cycle();
            drive_next();
         end
         chk(max_wait <= WAIT_MAX, "R9 bounded wait", max_wait, WAIT_MAX);
      end
      chk(bus_busy_o == '0, "R6 buses idle after drain", bus_busy_o, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule